// File: doc/BRIEF.md
# Dual-Edge Adaptive Synchronous Rectifier Gate Driver

This block drives the two secondary-side synchronous rectifier gates of a resonant converter from the two primary gate signals and from one conduction-detect flag per rectifier. For each rectifier it tracks two edges of the previous switching cycle. The first is how long the rectifier conducted, counted from the rise of its primary gate. The second is how far the end of conduction lagged behind the fall of the primary gate. In the next cycle the block turns these into two prediction windows, ANDs them, and trims the result by a programmable dead time at both ends.

The conduction flags come from an analog comparator and reach the block four clocks late at both edges. That delay is taken off each measured time. Rectifier A pairs with primary gate A and rectifier B with primary gate B. Light-load controls hold both rectifiers off (`pwm_mode`, `sr_skip`) or double the dead time (`sr_shrink`).

Every pin is a level-type control or status signal sampled on the rising clock edge. No pin carries a data stream, so there is no valid/ready handshake and no back-pressure. Each gate output is a register. It reflects the inputs sampled at the previous rising edge.

Top module: `sr_dual_edge_drv`

## Requirements
- R1: While `rst_n` is low, both gate outputs are low.
- R2: A rectifier's cycle starts in the clock in which its primary gate is first sampled high (phase t=0), and t counts clocks from there. In that cycle the gate may be high only for phases t with D <= t < L - D. L is the conduction length measured in the previous cycle, and D is the effective dead time in clocks (`dt_code`, see R8).
- R3: When the conduction flag fell while the primary gate was still high in the previous cycle, the gate goes low no later than the clock in which its primary gate is sampled low.
- R4: When the conduction flag fell after the primary gate fell in the previous cycle, the second window is the primary gate extended by max(0, G - D) clocks. G is the lag measured in that cycle, as defined in R6.
- R5: The gate drive is the AND of the conduction-length window (R2) and the stretched-primary window (R3, R4). Whichever ends first sets the turn-off.
- R6: Measurements subtract a fixed four-clock detection delay, with results floored at zero. L is the phase at which the flag is first sampled low after being high, minus 4. G is the clocks from the primary gate's fall to that flag fall, minus 4.
- R7: While `pwm_mode` or `sr_skip` is high at a rising edge, both gates are low after that edge.
- R8: With `sr_shrink` low, D equals `dt_code`. With `sr_shrink` high, D is twice `dt_code`. D applies at both turn-on and turn-off.
- R9: While `sr_en` is low, both gates are low and the measurements are discarded. After `sr_en` goes high, a rectifier stays low for its first cycle and drives only from its second primary rise onward.
- R10: The two gates are never high together. A gate may rise only if the other gate was low in the previous clock. When both request turn-on in the same clock with both gates low, gate A wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sr_en | input | 1 | Rectifier drive enable |
| pwm_mode | input | 1 | Converter is in fixed-frequency PWM mode; rectifiers held off |
| sr_skip | input | 1 | Light-load rectifier skip; rectifiers held off |
| sr_shrink | input | 1 | Doubles the dead time at both edges |
| dt_code | input | DT_W | Dead time in clocks |
| pri_gate_a | input | 1 | Primary gate A (pairs with rectifier A) |
| pri_gate_b | input | 1 | Primary gate B (pairs with rectifier B) |
| cond_a | input | 1 | Rectifier A conduction flag, delayed 4 clocks |
| cond_b | input | 1 | Rectifier B conduction flag, delayed 4 clocks |
| sr_gate_a | output | 1 | Rectifier A gate drive |
| sr_gate_b | output | 1 | Rectifier B gate drive |

## Verification
Every gate result is due exactly one rising edge after the inputs that decide it are sampled. The measurements feeding a cycle are due at the next primary rise. The bench changes inputs on the falling edge, advances its reference model by one step for those inputs, and compares both gates after the following rising edge. Hand-computed pulse widths are counted over whole switching periods whose first clock is a primary-A rise, so the one-clock register delay lines up with the count window. Enable, shrink, skip and overlap cases are each checked on the period after their settings take effect.

// File: rtl/sr_drv_pkg.sv
package sr_drv_pkg;

  // Default sizing shared by the tracker, predictor and top level.
  localparam int SRD_CNT_W   = 10;  // phase counters, saturating
  localparam int SRD_DT_W    = 4;   // dead-time code width
  localparam int SRD_DET_DLY = 4;   // conduction-flag detection delay, clocks

  // Edge events seen in the current clock for one rectifier channel.
  typedef struct packed {
    logic rise;   // primary gate first sampled high
    logic pfall;  // primary gate first sampled low
    logic cfall;  // conduction flag first sampled low
  } edge_flags_t;

  // Rectifier channel index.
  typedef enum logic {
    CH_A = 1'b0,
    CH_B = 1'b1
  } sr_chan_e;

endpackage

// File: rtl/sr_edge_tracker.sv
module sr_edge_tracker
  import sr_drv_pkg::*;
#(
  parameter int CNT_W   = SRD_CNT_W,
  parameter int DET_DLY = SRD_DET_DLY
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pri,
  input  logic             cond,
  output logic [CNT_W-1:0] t_now,
  output logic [CNT_W-1:0] s_now,
  output logic [CNT_W-1:0] len_eff,
  output logic [CNT_W-1:0] lag_eff,
  output logic             pf_act,
  output logic             valid_eff
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] DLY_C   = CNT_W'(DET_DLY);

  logic             pri_q, cond_q;
  logic             pf_seen, m_seen, armed, valid_q;
  logic [CNT_W-1:0] t_cnt, s_cnt, t_pf;
  logic [CNT_W-1:0] m_len, m_lag, len_q, lag_q;

  edge_flags_t      ev;
  logic             pf_seen_eff, m_seen_eff;
  logic [CNT_W-1:0] pf_stamp, gap, len_meas, lag_meas;

  always_comb begin
    ev.rise  = pri & ~pri_q;
    ev.pfall = ~pri & pri_q;
    ev.cfall = ~cond & cond_q;

    // Phase since primary rise, and clocks since primary fall.
    t_now = ev.rise  ? '0 : t_cnt;
    s_now = ev.pfall ? '0 : s_cnt;

    pf_seen_eff = ev.rise ? 1'b0 : pf_seen;
    m_seen_eff  = ev.rise ? 1'b0 : m_seen;
    pf_act      = ev.pfall | pf_seen_eff;

    pf_stamp = ev.pfall ? t_now : t_pf;
    gap      = t_now - pf_stamp;
    len_meas = (t_now > DLY_C) ? (t_now - DLY_C) : '0;
    lag_meas = (pf_act && (gap > DLY_C)) ? (gap - DLY_C) : '0;

    // At a primary rise the measurement of the cycle just ended is forwarded.
    len_eff   = ev.rise ? (m_seen ? m_len : '0) : len_q;
    lag_eff   = ev.rise ? (m_seen ? m_lag : '0) : lag_q;
    valid_eff = ev.rise ? armed : valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q   <= 1'b0;
      cond_q  <= 1'b0;
      pf_seen <= 1'b0;
      m_seen  <= 1'b0;
      armed   <= 1'b0;
      valid_q <= 1'b0;
      t_cnt   <= '0;
      s_cnt   <= '0;
      t_pf    <= '0;
      m_len   <= '0;
      m_lag   <= '0;
      len_q   <= '0;
      lag_q   <= '0;
    end else begin
      pri_q   <= pri;
      cond_q  <= cond;
      t_cnt   <= (t_now == CNT_MAX) ? t_now : t_now + 1'b1;
      s_cnt   <= (s_now == CNT_MAX) ? s_now : s_now + 1'b1;
      t_pf    <= pf_stamp;
      pf_seen <= pf_act;
      if (ev.cfall && !m_seen_eff) begin
        m_len <= len_meas;
        m_lag <= lag_meas;
      end
      m_seen <= m_seen_eff | ev.cfall;
      if (ev.rise) begin
        len_q   <= len_eff;
        lag_q   <= lag_eff;
        valid_q <= armed;
        armed   <= 1'b1;
      end
      if (!en) begin
        armed   <= 1'b0;
        valid_q <= 1'b0;
        m_seen  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sr_pulse_predictor.sv
module sr_pulse_predictor
  import sr_drv_pkg::*;
#(
  parameter int CNT_W = SRD_CNT_W,
  parameter int DT_W  = SRD_DT_W
) (
  input  logic             en,
  input  logic             hold_off,
  input  logic             pri,
  input  logic             pf_act,
  input  logic             valid_eff,
  input  logic [CNT_W-1:0] t_now,
  input  logic [CNT_W-1:0] s_now,
  input  logic [CNT_W-1:0] len_eff,
  input  logic [CNT_W-1:0] lag_eff,
  input  logic [DT_W:0]    dead,
  output logic             raw_on
);

  localparam int WW = CNT_W + 2;

  logic [WW-1:0] t_w, s_w, len_w, lag_w, dt_w, ext_w;
  logic          win_len, win_pri;

  always_comb begin
    t_w   = {2'b00, t_now};
    s_w   = {2'b00, s_now};
    len_w = {2'b00, len_eff};
    lag_w = {2'b00, lag_eff};
    dt_w  = {{(WW-DT_W-1){1'b0}}, dead};

    // Window 1: previous conduction length, trimmed at both ends.
    win_len = (t_w >= dt_w) && ((t_w + dt_w) < len_w);

    // Window 2: primary gate stretched by the previous turn-off lag.
    ext_w   = (lag_w > dt_w) ? (lag_w - dt_w) : '0;
    win_pri = pri | (pf_act & (s_w < ext_w));

    raw_on = en & valid_eff & ~hold_off & win_len & win_pri;
  end

endmodule

// File: rtl/sr_interlock.sv
module sr_interlock (
  input  logic clk,
  input  logic rst_n,
  input  logic req_a,
  input  logic req_b,
  output logic gate_a,
  output logic gate_b
);

  logic next_a, next_b;

  always_comb begin
    next_a = req_a & ~gate_b;
    next_b = req_b & ~gate_a & ~next_a;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_a <= 1'b0;
      gate_b <= 1'b0;
    end else begin
      gate_a <= next_a;
      gate_b <= next_b;
    end
  end

endmodule

// File: rtl/sr_dual_edge_drv.sv
module sr_dual_edge_drv
  import sr_drv_pkg::*;
#(
  parameter int CNT_W   = SRD_CNT_W,
  parameter int DT_W    = SRD_DT_W,
  parameter int DET_DLY = SRD_DET_DLY
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sr_en,
  input  logic            pwm_mode,
  input  logic            sr_skip,
  input  logic            sr_shrink,
  input  logic [DT_W-1:0] dt_code,
  input  logic            pri_gate_a,
  input  logic            pri_gate_b,
  input  logic            cond_a,
  input  logic            cond_b,
  output logic            sr_gate_a,
  output logic            sr_gate_b
);

  localparam int NCH = 2;

  logic [DT_W:0]      dead;
  logic               hold_off;
  logic [NCH-1:0]     pri_v, cond_v, raw_v, pf_v, valid_v;
  logic [CNT_W-1:0]   t_v   [NCH];
  logic [CNT_W-1:0]   s_v   [NCH];
  logic [CNT_W-1:0]   len_v [NCH];
  logic [CNT_W-1:0]   lag_v [NCH];

  always_comb begin
    dead     = sr_shrink ? {dt_code, 1'b0} : {1'b0, dt_code};
    hold_off = pwm_mode | sr_skip;
    pri_v[CH_A]  = pri_gate_a;
    pri_v[CH_B]  = pri_gate_b;
    cond_v[CH_A] = cond_a;
    cond_v[CH_B] = cond_b;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    sr_edge_tracker #(
      .CNT_W   (CNT_W),
      .DET_DLY (DET_DLY)
    ) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (sr_en),
      .pri       (pri_v[ch]),
      .cond      (cond_v[ch]),
      .t_now     (t_v[ch]),
      .s_now     (s_v[ch]),
      .len_eff   (len_v[ch]),
      .lag_eff   (lag_v[ch]),
      .pf_act    (pf_v[ch]),
      .valid_eff (valid_v[ch])
    );

    sr_pulse_predictor #(
      .CNT_W (CNT_W),
      .DT_W  (DT_W)
    ) u_pred (
      .en        (sr_en),
      .hold_off  (hold_off),
      .pri       (pri_v[ch]),
      .pf_act    (pf_v[ch]),
      .valid_eff (valid_v[ch]),
      .t_now     (t_v[ch]),
      .s_now     (s_v[ch]),
      .len_eff   (len_v[ch]),
      .lag_eff   (lag_v[ch]),
      .dead      (dead),
      .raw_on    (raw_v[ch])
    );
  end

  sr_interlock u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_a  (raw_v[CH_A]),
    .req_b  (raw_v[CH_B]),
    .gate_a (sr_gate_a),
    .gate_b (sr_gate_b)
  );

endmodule

// File: rtl/sr_dual_edge_drv_chk.sv
module sr_dual_edge_drv_chk (
  input logic clk,
  input logic rst_n,
  input logic sr_en,
  input logic pwm_mode,
  input logic sr_skip,
  input logic sr_gate_a,
  input logic sr_gate_b
);

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(sr_gate_a && sr_gate_b));

  assert_b_waits_for_a_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_gate_b) |-> !$past(sr_gate_a));

  assert_a_waits_for_b_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_gate_a) |-> !$past(sr_gate_b));

  assert_hold_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode || sr_skip) |=> (!sr_gate_a && !sr_gate_b));

  assert_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_en |=> (!sr_gate_a && !sr_gate_b));

endmodule

bind sr_dual_edge_drv sr_dual_edge_drv_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sr_en     (sr_en),
  .pwm_mode  (pwm_mode),
  .sr_skip   (sr_skip),
  .sr_gate_a (sr_gate_a),
  .sr_gate_b (sr_gate_b)
);

// File: tb/sr_dual_edge_drv_test.sv
module sr_dual_edge_drv_test;

  localparam int CLK_PERIOD = 10;
  localparam int DT_W = 4;
  localparam int DLY  = 4;
  localparam int CMAX = 1023;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sr_en = 1'b0, pwm_mode = 1'b0, sr_skip = 1'b0, sr_shrink = 1'b0;
  logic [DT_W-1:0] dt_code = '0;
  logic pri_gate_a = 1'b0, pri_gate_b = 1'b0, cond_a = 1'b0, cond_b = 1'b0;
  logic sr_gate_a, sr_gate_b;

  int n_cmp = 0, n_bad = 0;
  int cnt_a = 0, cnt_b = 0, cnt_both = 0;
  bit done = 0;
  string cur_req = "R1";

  // Reference model state per channel.
  bit md_p[2], md_c[2], md_pfs[2], md_ms[2], md_armed[2], md_valid[2];
  int md_t[2], md_s[2], md_tpf[2], md_mlen[2], md_mlag[2], md_len[2], md_lag[2];
  bit exp_a = 0, exp_b = 0;

  sr_dual_edge_drv uut (
    .clk(clk), .rst_n(rst_n), .sr_en(sr_en), .pwm_mode(pwm_mode),
    .sr_skip(sr_skip), .sr_shrink(sr_shrink), .dt_code(dt_code),
    .pri_gate_a(pri_gate_a), .pri_gate_b(pri_gate_b),
    .cond_a(cond_a), .cond_b(cond_b),
    .sr_gate_a(sr_gate_a), .sr_gate_b(sr_gate_b)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One rectifier: request for this clock, then advance its tracked state.
  task automatic chan_step(input int ch, input bit p, input bit c, output bit raw);
    bit rise, pfall, cfall, pfs_e, ms_e, pfa, val_e, w1, w2;
    int t, s, le, lg, dte, ext, stamp, gap;
    rise  = p && !md_p[ch];
    pfall = !p && md_p[ch];
    cfall = !c && md_c[ch];
    t = rise ? 0 : md_t[ch];
    s = pfall ? 0 : md_s[ch];
    pfs_e = rise ? 1'b0 : md_pfs[ch];
    ms_e  = rise ? 1'b0 : md_ms[ch];
    pfa   = pfall || pfs_e;
    le = rise ? (md_ms[ch] ? md_mlen[ch] : 0) : md_len[ch];
    lg = rise ? (md_ms[ch] ? md_mlag[ch] : 0) : md_lag[ch];
    val_e = rise ? md_armed[ch] : md_valid[ch];
    dte = sr_shrink ? 2 * int'(dt_code) : int'(dt_code);
    w1  = (t >= dte) && (t + dte < le);
    ext = (lg > dte) ? lg - dte : 0;
    w2  = p || (pfa && (s < ext));
    raw = sr_en && val_e && !pwm_mode && !sr_skip && w1 && w2;
    stamp = pfall ? t : md_tpf[ch];
    gap   = t - stamp;
    if (cfall && !ms_e) begin
      md_mlen[ch] = (t > DLY) ? t - DLY : 0;
      md_mlag[ch] = (pfa && gap > DLY) ? gap - DLY : 0;
    end
    md_ms[ch] = ms_e || cfall;
    if (rise) begin
      md_len[ch] = le;
      md_lag[ch] = lg;
      md_valid[ch] = md_armed[ch];
      md_armed[ch] = 1'b1;
    end
    if (!sr_en) begin
      md_armed[ch] = 1'b0;
      md_valid[ch] = 1'b0;
      md_ms[ch] = 1'b0;
    end
    md_t[ch] = (t + 1 > CMAX) ? CMAX : t + 1;
    md_s[ch] = (s + 1 > CMAX) ? CMAX : s + 1;
    md_tpf[ch] = stamp;
    md_pfs[ch] = pfa;
    md_p[ch] = p;
    md_c[ch] = c;
  endtask

  task automatic do_clock(input bit pa, input bit pb, input bit ca, input bit cb);
    bit ra, rb, na, nb;
    pri_gate_a = pa; pri_gate_b = pb; cond_a = ca; cond_b = cb;
    chan_step(0, pa, ca, ra);
    chan_step(1, pb, cb, rb);
    na = ra && !exp_b;
    nb = rb && !exp_a && !na;
    exp_a = na; exp_b = nb;
    @(posedge clk);
    @(negedge clk);
    check(cur_req, "sr_gate_a", sr_gate_a, exp_a);
    check(cur_req, "sr_gate_b", sr_gate_b, exp_b);
    if (sr_gate_a) cnt_a++;
    if (sr_gate_b) cnt_b++;
    if (sr_gate_a && sr_gate_b) cnt_both++;
  endtask

  // Symmetric half-bridge periods; cond offsets relative to their primary rise.
  task automatic run_period(input int h, input int pd, input int cfa, input int cfb, input int nper);
    for (int n = 0; n < nper; n++) begin
      for (int k = 0; k < 2 * h; k++) begin
        do_clock(k < h - pd, (k >= h) && (k < 2 * h - pd),
                 (k >= 2) && (k < cfa), (k >= h + 2) && (k < h + cfb));
      end
    end
  endtask

  task automatic clr_counts();
    cnt_a = 0; cnt_b = 0; cnt_both = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", "sr_gate_a in reset", sr_gate_a, 0);
    check("R1", "sr_gate_b in reset", sr_gate_b, 0);
    rst_n = 1'b1;

    // R9: first cycle after enable stays low, second drives (R2 window 20).
    cur_req = "R9"; sr_en = 1'b1; dt_code = 4'd3;
    clr_counts(); run_period(40, 2, 30, 30, 1);
    check("R9", "gate_a highs, first cycle", cnt_a, 0);
    check("R9", "gate_b highs, first cycle", cnt_b, 0);
    cur_req = "R2";
    clr_counts(); run_period(40, 2, 30, 30, 1);
    check("R2", "gate_a highs, window D..L-D", cnt_a, 20);
    check("R2", "gate_b highs, window D..L-D", cnt_b, 20);

    // R6: detection delay removed; D=0 gives L = 30 - 4.
    cur_req = "R6"; dt_code = 4'd0;
    clr_counts(); run_period(40, 2, 30, 30, 1);
    check("R6", "gate_a highs with D=0", cnt_a, 26);

    // R8: shrink doubles D to 6 at both ends.
    cur_req = "R8"; dt_code = 4'd3; sr_shrink = 1'b1;
    clr_counts(); run_period(40, 2, 30, 30, 1);
    check("R8", "gate_a highs with shrink", cnt_a, 14);
    check("R8", "gate_b highs with shrink", cnt_b, 14);
    sr_shrink = 1'b0;

    // R7: PWM mode and skip hold both rectifiers off.
    cur_req = "R7"; pwm_mode = 1'b1;
    clr_counts(); run_period(40, 2, 30, 30, 1);
    check("R7", "highs in pwm mode", cnt_a + cnt_b, 0);
    pwm_mode = 1'b0; sr_skip = 1'b1;
    clr_counts(); run_period(40, 2, 30, 30, 1);
    check("R7", "highs in skip", cnt_a + cnt_b, 0);
    sr_skip = 1'b0;

    // R3: conduction ended before primary fall; shorter primary cuts the gate.
    cur_req = "R3"; dt_code = 4'd0;
    run_period(40, 2, 30, 30, 1);
    clr_counts(); run_period(40, 20, 30, 30, 1);
    check("R3", "gate_a highs, primary 20 clocks", cnt_a, 20);

    // R4: above resonance, primary 32 clocks, flag falls at 40, D=2 -> window 2..34.
    cur_req = "R4"; dt_code = 4'd2;
    run_period(40, 8, 40, 40, 2);
    clr_counts(); run_period(40, 8, 40, 40, 1);
    check("R4", "gate_a highs with extension", cnt_a, 32);

    // R5: prior lag 14, primary shortened to 20: stretched window ends first at 34.
    cur_req = "R5"; dt_code = 4'd0;
    run_period(40, 8, 50, 30, 2);
    clr_counts(); run_period(40, 20, 50, 30, 1);
    check("R5", "gate_a highs, AND limited by window 2", cnt_a, 34);

    // R10: gate A held 66 clocks covers gate B's whole request.
    cur_req = "R10";
    run_period(40, 2, 70, 30, 2);
    clr_counts(); run_period(40, 2, 70, 30, 1);
    check("R10", "clocks with both high", cnt_both, 0);
    check("R10", "gate_a highs", cnt_a, 66);
    check("R10", "gate_b highs while blocked", cnt_b, 0);

    // R9: disabling drops drive and measurements.
    cur_req = "R9"; sr_en = 1'b0;
    clr_counts(); run_period(40, 2, 30, 30, 1);
    check("R9", "highs while disabled", cnt_a + cnt_b, 0);
    sr_en = 1'b1;
    clr_counts(); run_period(40, 2, 30, 30, 1);
    check("R9", "highs in first cycle after re-enable", cnt_a, 0);

    // Random periods against the model: R2 R4 R5 R7 R8 R10.
    cur_req = "R2 R4 R5 random";
    clr_counts();
    for (int i = 0; i < 60; i++) begin
      int h, pd;
      h  = $urandom_range(60, 16);
      pd = $urandom_range(6, 1);
      dt_code   = 4'($urandom_range(7, 0));
      sr_shrink = ($urandom_range(3, 0) == 0);
      pwm_mode  = ($urandom_range(9, 0) == 0);
      sr_skip   = ($urandom_range(9, 0) == 0);
      run_period(h, pd, $urandom_range(2 * h - 1, 3), $urandom_range(2 * h - 1, 3), 1);
    end
    check("R10", "random clocks with both high", cnt_both, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule